// File: doc/BRIEF.md
# Four-Digit Combination Lock Controller

This block is the central state machine of a digital safe. Four switches present a 4-bit digit value (0x0 to 0xF), and three single-cycle, already debounced strobes drive it. `btn_confirm` captures the switch value as the next code digit. `btn_reset` discards the entry so a fresh attempt can start. `btn_relock` closes the safe. Once the fourth digit is captured, the entered sequence is compared with a code fixed by the `SECRET` parameter. A match opens the safe, and a mismatch raises the error state.

The states are ST_LOCK, ST_OPEN and ST_ERR. The reset state is ST_LOCK. The transitions are:

- ST_LOCK to ST_OPEN, taken on the fourth accepted confirm when the code matches.
- ST_LOCK to ST_ERR, taken on the fourth accepted confirm when the code does not match.
- ST_OPEN to ST_LOCK and ST_ERR to ST_LOCK, taken on either `btn_reset` or `btn_relock`.

The outputs are decoded from the state register:

- a one-hot RGB colour;
- a locked flag;
- an error flag.

A relay output drives a sounder. It pulses for a parameterised number of cycles each time the safe goes from ST_OPEN to ST_LOCK. The entry index, the per-digit completion mask and the live switch value are exported for a display block.

Top module: `safe_lock_ctrl`

## Requirements
- R1: After `rst_n` is released the block is in ST_LOCK. In that state `rgb` is 3'b100, `lock_flag` is 1, `err_flag` is 0, `entry_idx` is 0, `entry_mask` is 0 and `relay_on` is 0.
- R2: An accepted `btn_confirm` captures `sw_digit` as the next digit, with the first digit entered being the most significant nibble of `SECRET`. On the next edge it sets `entry_mask` bit k, where k is the number of digits captured before it (bit 0 is the first digit). `entry_idx` equals the number of captured digits, saturating at 3.
- R3: When the fourth confirm is accepted and all four digits equal `SECRET`, the state becomes ST_OPEN on that same edge. `rgb` is then 3'b010 and `lock_flag` is 0.
- R4: When the fourth confirm is accepted and any digit differs from `SECRET`, the state becomes ST_ERR on that same edge. `rgb` is then 3'b001 and `err_flag` is 1.
- R5: While four digits are held, `btn_confirm` has no effect on the mask, the index or the state until the next `btn_reset`.
- R6: `btn_reset` clears every captured digit, the mask and the index, and moves to ST_LOCK with `err_flag` low.
- R7: `btn_relock` moves to ST_LOCK from any state, which clears `err_flag`. It leaves the captured digits and the mask unchanged.
- R8: `relay_on` is high for exactly `RELAY_CYCLES` cycles, starting on the edge where the state goes from ST_OPEN to ST_LOCK. No other transition asserts it, including ST_ERR to ST_LOCK.
- R9: Strobes are prioritised in the order `btn_reset`, then `btn_relock`, then `btn_confirm`. A confirm that arrives together with either other strobe is discarded.
- R10: `rgb` is {red, green, blue} and exactly one bit is set at all times. `lock_flag` is high in both ST_LOCK and ST_ERR.
- R11: `cur_digit` always equals `sw_digit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_reset | input | 1 | Strobe: discard entry, return to locked |
| btn_relock | input | 1 | Strobe: close the safe |
| btn_confirm | input | 1 | Strobe: capture the switch value as the next digit |
| sw_digit | input | 4 | Digit value from the switches |
| rgb | output | 3 | Status colour {red, green, blue}, one-hot |
| lock_flag | output | 1 | High unless the safe is open |
| err_flag | output | 1 | High in the error state |
| relay_on | output | 1 | Sounder relay pulse |
| entry_idx | output | 2 | Number of captured digits, saturating at 3 |
| entry_mask | output | 4 | One bit per captured digit |
| cur_digit | output | 4 | Live switch value for the display |

## Verification
The comparison is tried with four kinds of entry:
- the exact code, including the boundary digits 0xF and 0x0;
- a sequence wrong only in its last digit, which shows that every slot takes part in the comparison;
- a sequence wrong only in its first digit, which exposes a reversed digit order;
- a second correct entry after an error, which shows that reset restores the comparison.

Extra confirms after completion, together with strobes arriving in the same cycle, separate the saturation and priority rules. Relocking from ST_OPEN and from ST_ERR tells a relay that follows the state change apart from one that follows any entry into ST_LOCK.

// File: rtl/safe_lock_pkg.sv
package safe_lock_pkg;

    typedef enum logic [1:0] {
        ST_LOCK = 2'd0,
        ST_OPEN = 2'd1,
        ST_ERR  = 2'd2
    } lock_state_t;

    localparam logic [2:0] RGB_RED   = 3'b100;
    localparam logic [2:0] RGB_GREEN = 3'b010;
    localparam logic [2:0] RGB_BLUE  = 3'b001;

    typedef struct packed {
        logic [2:0] rgb;
        logic       locked;
        logic       error;
    } status_t;

endpackage

// File: rtl/digit_capture.sv
module digit_capture #(
    parameter int DIGITS  = 4,
    parameter int DIGIT_W = 4,
    localparam int CODE_W = DIGITS * DIGIT_W,
    localparam int CNT_W  = $clog2(DIGITS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               take,
    input  logic [DIGIT_W-1:0] digit_in,
    output logic [CODE_W-1:0]  code_next,
    output logic [CNT_W-1:0]   count,
    output logic [DIGITS-1:0]  mask,
    output logic               completing
);

    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  count_q;
    logic [DIGITS-1:0] mask_q;
    logic              accept;

    assign accept     = take && !clear && (count_q < CNT_W'(DIGITS));
    assign completing = accept && (count_q == CNT_W'(DIGITS - 1));

    // slot k holds the k-th entered digit in the k-th most significant nibble
    for (genvar k = 0; k < DIGITS; k++) begin : g_slot
        localparam int LSB = (DIGITS - 1 - k) * DIGIT_W;
        logic hit;
        assign hit = accept && (count_q == CNT_W'(k));

        always_comb begin
            code_next[LSB +: DIGIT_W] = hit ? digit_in : code_q[LSB +: DIGIT_W];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                code_q[LSB +: DIGIT_W] <= '0;
                mask_q[k]              <= 1'b0;
            end else if (clear) begin
                code_q[LSB +: DIGIT_W] <= '0;
                mask_q[k]              <= 1'b0;
            end else if (hit) begin
                code_q[LSB +: DIGIT_W] <= digit_in;
                mask_q[k]              <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (accept) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;
    assign mask  = mask_q;

endmodule

// File: rtl/code_compare.sv
module code_compare #(
    parameter int DIGITS  = 4,
    parameter int DIGIT_W = 4,
    localparam int CODE_W = DIGITS * DIGIT_W
) (
    input  logic [CODE_W-1:0] entered,
    input  logic [CODE_W-1:0] secret,
    output logic              match
);

    logic [DIGITS-1:0] eq;

    for (genvar k = 0; k < DIGITS; k++) begin : g_eq
        assign eq[k] = (entered[k*DIGIT_W +: DIGIT_W] == secret[k*DIGIT_W +: DIGIT_W]);
    end

    assign match = &eq;

endmodule

// File: rtl/relay_timer.sv
module relay_timer #(
    parameter int CYCLES = 10_000_000,
    localparam int TW    = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic active
);

    logic [TW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (fire) begin
            left_q <= TW'(CYCLES);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign active = (left_q != '0);

endmodule

// File: rtl/safe_lock_ctrl.sv
module safe_lock_ctrl
    import safe_lock_pkg::*;
#(
    parameter int                         DIGITS       = 4,
    parameter int                         DIGIT_W      = 4,
    parameter logic [DIGITS*DIGIT_W-1:0]  SECRET       = 16'h1234,
    parameter int                         RELAY_CYCLES = 10_000_000,
    localparam int                        CODE_W       = DIGITS * DIGIT_W,
    localparam int                        CNT_W        = $clog2(DIGITS + 1),
    localparam int                        IDX_W        = $clog2(DIGITS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               btn_reset,
    input  logic               btn_relock,
    input  logic               btn_confirm,
    input  logic [DIGIT_W-1:0] sw_digit,
    output logic [2:0]         rgb,
    output logic               lock_flag,
    output logic               err_flag,
    output logic               relay_on,
    output logic [IDX_W-1:0]   entry_idx,
    output logic [DIGITS-1:0]  entry_mask,
    output logic [DIGIT_W-1:0] cur_digit
);

    lock_state_t       state_q, state_d;
    status_t           status;
    logic [CODE_W-1:0] code_next;
    logic [CNT_W-1:0]  count;
    logic              completing;
    logic              match;
    logic              take;
    logic              fire_relay;

    // relock and reset both outrank a confirm in the same cycle
    assign take = btn_confirm && !btn_relock && !btn_reset;

    digit_capture #(
        .DIGITS (DIGITS),
        .DIGIT_W(DIGIT_W)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (btn_reset),
        .take      (take),
        .digit_in  (sw_digit),
        .code_next (code_next),
        .count     (count),
        .mask      (entry_mask),
        .completing(completing)
    );

    code_compare #(
        .DIGITS (DIGITS),
        .DIGIT_W(DIGIT_W)
    ) u_compare (
        .entered(code_next),
        .secret (SECRET),
        .match  (match)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCK: begin
                if (btn_reset || btn_relock) state_d = ST_LOCK;
                else if (completing)         state_d = match ? ST_OPEN : ST_ERR;
            end
            ST_OPEN: begin
                if (btn_reset || btn_relock) state_d = ST_LOCK;
            end
            ST_ERR: begin
                if (btn_reset || btn_relock) state_d = ST_LOCK;
            end
            default: state_d = ST_LOCK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCK;
        else        state_q <= state_d;
    end

    assign fire_relay = (state_q == ST_OPEN) && (state_d == ST_LOCK);

    relay_timer #(
        .CYCLES(RELAY_CYCLES)
    ) u_relay (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire_relay),
        .active(relay_on)
    );

    always_comb begin
        status = '{rgb: RGB_RED, locked: 1'b1, error: 1'b0};
        unique case (state_q)
            ST_LOCK: status = '{rgb: RGB_RED,   locked: 1'b1, error: 1'b0};
            ST_OPEN: status = '{rgb: RGB_GREEN, locked: 1'b0, error: 1'b0};
            ST_ERR:  status = '{rgb: RGB_BLUE,  locked: 1'b1, error: 1'b1};
            default: status = '{rgb: RGB_RED,   locked: 1'b1, error: 1'b0};
        endcase
    end

    assign rgb       = status.rgb;
    assign lock_flag = status.locked;
    assign err_flag  = status.error;
    assign entry_idx = (count >= CNT_W'(DIGITS)) ? IDX_W'(DIGITS - 1) : count[IDX_W-1:0];
    assign cur_digit = sw_digit;

endmodule

// File: rtl/safe_lock_chk.sv
module safe_lock_chk #(
    parameter int DIGITS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              btn_reset,
    input logic              btn_relock,
    input logic              btn_confirm,
    input logic [2:0]        rgb,
    input logic              lock_flag,
    input logic              err_flag,
    input logic              relay_on,
    input logic [DIGITS-1:0] entry_mask
);

    assert_rgb_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(rgb));

    assert_lock_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lock_flag == !rgb[1]);

    assert_err_blue_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag == rgb[0]);

    assert_relay_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(relay_on) |-> ($past(rgb) == 3'b010) && (rgb == 3'b100));

    assert_full_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (btn_confirm && !btn_reset && !btn_relock && (&entry_mask)) |=> $stable(entry_mask));

    assert_reset_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        btn_reset |=> (entry_mask == '0) && (rgb == 3'b100) && !err_flag);

    assert_relock_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (btn_relock && !btn_reset) |=> (rgb == 3'b100) && $stable(entry_mask));

endmodule

bind safe_lock_ctrl safe_lock_chk #(.DIGITS(DIGITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .btn_reset  (btn_reset),
    .btn_relock (btn_relock),
    .btn_confirm(btn_confirm),
    .rgb        (rgb),
    .lock_flag  (lock_flag),
    .err_flag   (err_flag),
    .relay_on   (relay_on),
    .entry_mask (entry_mask)
);

// File: tb/safe_lock_ctrl_bench.sv
`timescale 1ns/1ps
module safe_lock_ctrl_bench;

    localparam logic [15:0] CODE  = 16'hF0C3;
    localparam int          RELAY = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       b_rst = 1'b0, b_lock = 1'b0, b_conf = 1'b0;
    logic [3:0] sw = 4'h0;
    logic [2:0] rgb;
    logic       lock_flag, err_flag, relay_on;
    logic [1:0] entry_idx;
    logic [3:0] entry_mask, cur_digit;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    safe_lock_ctrl #(
        .SECRET      (CODE),
        .RELAY_CYCLES(RELAY)
    ) u_safe_lock_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .btn_reset  (b_rst),
        .btn_relock (b_lock),
        .btn_confirm(b_conf),
        .sw_digit   (sw),
        .rgb        (rgb),
        .lock_flag  (lock_flag),
        .err_flag   (err_flag),
        .relay_on   (relay_on),
        .entry_idx  (entry_idx),
        .entry_mask (entry_mask),
        .cur_digit  (cur_digit)
    );

    // reference model: 0 locked, 1 open, 2 error
    int         m_state = 0;
    int         m_relay = 0;
    logic [3:0] m_digits[$];

    always @(posedge clk) begin
        int prev;
        logic [15:0] got;
        prev = m_state;
        if (!rst_n) begin
            m_digits.delete();
            m_state = 0;
            m_relay = 0;
        end else begin
            if (b_rst) begin
                m_digits.delete();
                m_state = 0;
            end else if (b_lock) begin
                m_state = 0;
            end else if (b_conf && m_digits.size() < 4) begin
                m_digits.push_back(sw);
                if (m_digits.size() == 4) begin
                    got = {m_digits[0], m_digits[1], m_digits[2], m_digits[3]};
                    m_state = (got == CODE) ? 1 : 2;
                end
            end
            if (prev == 1 && m_state == 0) m_relay = RELAY;
            else if (m_relay > 0)          m_relay = m_relay - 1;
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every cycle, half a period after the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int n;
            n = m_digits.size();
            check("R10/R3/R4 rgb", int'(rgb), (m_state == 1) ? 2 : (m_state == 2) ? 1 : 4);
            check("R10 lock_flag", int'(lock_flag), (m_state != 1) ? 1 : 0);
            check("R4 err_flag", int'(err_flag), (m_state == 2) ? 1 : 0);
            check("R2 entry_mask", int'(entry_mask), (1 << n) - 1);
            check("R2 entry_idx", int'(entry_idx), (n > 3) ? 3 : n);
            check("R8 relay_on", int'(relay_on), (m_relay > 0) ? 1 : 0);
            check("R11 cur_digit", int'(cur_digit), int'(sw));
        end
    end

    task automatic drive(bit r, bit l, bit c, logic [3:0] d);
        @(posedge clk); #2;
        b_rst = r; b_lock = l; b_conf = c; sw = d;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, sw);
    endtask

    task automatic enter(logic [15:0] v);
        for (int i = 3; i >= 0; i--) begin
            drive(0, 0, 1, v[i*4 +: 4]);
            drive(0, 0, 0, 4'h7);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1: reset state, compared every cycle
        idle(2);
        @(negedge clk);
        check("R1 rgb", int'(rgb), 4);
        check("R1 mask", int'(entry_mask), 0);
        check("R1 relay", int'(relay_on), 0);
        // R2 R3: correct code with boundary digits 0xF and 0x0
        enter(CODE);
        idle(2);
        // R5: confirms after completion are ignored
        drive(0, 0, 1, 4'h9); drive(0, 0, 1, 4'h1); idle(1);
        // R8 R7: relock from open fires relay, keeps entry
        drive(0, 1, 0, 4'h0); idle(RELAY + 3);
        // R6: reset, then wrong last digit -> R4
        drive(1, 0, 0, 4'h0); idle(1);
        enter(16'hF0C2); idle(2);
        // R8: relock from error gives no relay
        drive(0, 1, 0, 4'h0); idle(RELAY + 2);
        // wrong first digit
        drive(1, 0, 0, 4'h0); enter(16'h00C3); idle(1);
        // recovery: reset then correct code; reset from open fires relay
        drive(1, 0, 0, 4'h0); enter(CODE); idle(1);
        drive(1, 0, 0, 4'h0); idle(2);
        // R9: priority with partial entry
        drive(0, 0, 1, 4'hF); drive(0, 1, 1, 4'h0); drive(1, 1, 1, 4'h0);
        drive(0, 0, 1, 4'hF); drive(1, 0, 1, 4'h0); idle(2);
        @(negedge clk);
        check("R9 mask after strobes", int'(entry_mask), 0);
        // R2: saturation of index with live switch changes (R11)
        enter(CODE); drive(0, 0, 0, 4'hA); drive(0, 0, 0, 4'h5);
        drive(0, 1, 0, 4'h0); idle(RELAY + 2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual hang expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule